// File: doc/BRIEF.md
# Pipelined Single-Precision Add/Subtract/Multiply Unit

This block performs IEEE-754 single-precision addition, subtraction and multiplication in a fixed-latency pipeline. On every clock edge it can accept a new pair of 32-bit operands, together with an operation select and a rounding mode. Three clock edges later it returns the rounded result and a five-bit exception vector. Nothing stalls, so results leave in issue order, one per cycle.

Subnormal numbers are not supported. A subnormal input counts as a signed zero. A result too small to be a normal number becomes a zero of the same sign. All four rounding directions can be chosen per operation. Every NaN result is the same canonical quiet NaN.

Top module: `fp32_arith_pipe`

## Requirements
- R1: An operation sampled with `in_valid` high at rising edge k shows its result and flags after edge k+3, with `out_valid` high for that one cycle. `out_valid` equals `in_valid` delayed by exactly three edges. Back-to-back issue is accepted every cycle. After reset, `out_valid`, `res` and `exc` are 0.
- R2: `op_sel` 2'b00 adds, 2'b01 computes a minus b, and 2'b1x multiplies. For normal operands with an exact result, the output is that exact value with no flag set.
- R3: `rmode` 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 toward +infinity and 2'b11 toward -infinity.
- R4: Any input with a zero exponent field counts as a zero carrying that input's sign. Flushing an input raises no flag.
- R5: A result whose exponent is below the minimum normal after rounding is returned as a zero of the result's sign, with underflow and inexact set. `res` never carries a subnormal encoding.
- R6: On overflow, the result is infinity in round-to-nearest, and in a directed mode that points away from zero for that sign. Otherwise it is the largest finite value of that sign. Overflow and inexact are both set.
- R7: Every NaN result is 32'h7FC00000. Invalid is raised for infinity minus infinity (after applying the operation's sign), for zero times infinity, and for any signaling NaN input (fraction MSB clear). A quiet NaN input alone raises no flag.
- R8: `exc` bit 4 is invalid, bit 3 divide-by-zero (always 0), bit 2 overflow, bit 1 underflow and bit 0 inexact. Inexact is set whenever rounding discards nonzero bits.
- R9: An exact zero sum of opposite-signed values is +0, except in round toward -infinity, where it is -0. A sum of two zeros of like sign keeps that sign.
- R10: Infinity plus a finite value is that infinity. Infinity times a nonzero finite value, or times infinity, is an infinity whose sign is the XOR of the operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| op_sel | input | 2 | 00 add, 01 subtract, 1x multiply |
| rmode | input | 2 | 00 nearest-even, 01 to zero, 10 to +inf, 11 to -inf |
| out_valid | output | 1 | Result present this cycle |
| res | output | 32 | Rounded single-precision result |
| exc | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
The rounding increment and overflow detection can fire in the same cycle. This happens when the largest finite value gains exactly half an ulp: the round-up carries out of the fraction and pushes the exponent to the reserved value. The bench provokes this by adding 2^103 to the largest finite value under all four modes. Nearest-even and toward +infinity must yield infinity with overflow and inexact. Toward zero and toward -infinity must leave the largest finite value with only inexact. The same cycle-level overlap is exercised for underflow by flushing products just below the normal range. A back-to-back stream with mixed modes shows that no result or flag leaks into its neighbour.

// File: rtl/fp32_arith_pipe.sv
module fp32_arith_pipe (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] a_in,
  input  logic [31:0] b_in,
  input  logic [1:0]  op_sel,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [31:0] res,
  output logic [4:0]  exc
);
  localparam int W = 51;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  // stage 1: unpack, special values, alignment
  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  logic sa, sb, za, zb, ia, ib, na, nb, is_mul, swap;

  assign ea = a_in[30:23];
  assign eb = b_in[30:23];
  assign fa = a_in[22:0];
  assign fb = b_in[22:0];
  assign sa = a_in[31];
  assign sb = b_in[31] ^ (~op_sel[1] & op_sel[0]);
  assign za = (ea == 8'd0);
  assign zb = (eb == 8'd0);
  assign ia = (ea == 8'hFF) && (fa == 23'd0);
  assign ib = (eb == 8'hFF) && (fb == 23'd0);
  assign na = (ea == 8'hFF) && (fa != 23'd0);
  assign nb = (eb == 8'hFF) && (fb != 23'd0);
  assign is_mul = op_sel[1];
  assign swap = b_in[30:0] > a_in[30:0];

  logic        sp_c;
  logic [31:0] spr_c;
  logic [4:0]  spf_c;
  always_comb begin
    sp_c = 1'b1; spr_c = QNAN; spf_c = 5'd0;
    if (na | nb) spf_c[4] = (na & ~fa[22]) | (nb & ~fb[22]);
    else if (is_mul) begin
      if ((ia & zb) | (za & ib)) spf_c[4] = 1'b1;
      else if (ia | ib)          spr_c = {sa ^ sb, 8'hFF, 23'd0};
      else if (za | zb)          spr_c = {sa ^ sb, 31'd0};
      else                       sp_c = 1'b0;
    end else begin
      if (ia & ib & (sa != sb))  spf_c[4] = 1'b1;
      else if (ia)               spr_c = {sa, 8'hFF, 23'd0};
      else if (ib)               spr_c = {sb, 8'hFF, 23'd0};
      else if (za & zb)          spr_c = {(sa == sb) ? sa : (rmode == 2'b11), 31'd0};
      else if (za)               spr_c = {sb, b_in[30:0]};
      else if (zb)               spr_c = a_in;
      else                       sp_c = 1'b0;
    end
  end

  logic [7:0]   el, es, dexp;
  logic [23:0]  gl, gs;
  logic [W-1:0] xs, al;
  always_comb begin
    el = swap ? eb : ea;
    es = swap ? ea : eb;
    gl = {1'b1, swap ? fb : fa};
    gs = {1'b1, swap ? fa : fb};
    dexp = el - es;
    xs = {1'b0, gs, 26'd0};
    if (dexp > 8'd50) al = W'(1);
    else begin
      al = xs >> dexp;
      al[0] = al[0] | ((xs & ((W'(1) << dexp) - W'(1))) != '0);
    end
  end

  logic v1, v2, v3, mul1, sub1, s1, s2, s3, sp1, sp2, sp3;
  logic [1:0]  rm1, rm2, rm3;
  logic [31:0] spr1, spr2, spr3;
  logic [4:0]  spf1, spf2, spf3;
  logic signed [10:0] e1, e2, e3;
  logic [W-1:0] x1, y1, m2;
  logic [22:0] fr3;
  logic g3, st3, z3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2;
    end

  always_ff @(posedge clk) begin
    mul1 <= is_mul; sub1 <= sa ^ sb; rm1 <= rmode;
    sp1 <= sp_c; spr1 <= spr_c; spf1 <= spf_c;
    s1 <= is_mul ? (sa ^ sb) : (swap ? sb : sa);
    e1 <= is_mul ? ({3'd0, ea} + {3'd0, eb} - 11'd127) : {3'd0, el};
    x1 <= is_mul ? {27'd0, 1'b1, fa} : {1'b0, gl, 26'd0};
    y1 <= is_mul ? {27'd0, 1'b1, fb} : al;
  end

  // stage 2: mantissa add, subtract or multiply
  logic [47:0] prod;
  assign prod = 48'(x1[23:0]) * 48'(y1[23:0]);

  always_ff @(posedge clk) begin
    s2 <= s1; e2 <= e1; rm2 <= rm1; sp2 <= sp1; spr2 <= spr1; spf2 <= spf1;
    m2 <= mul1 ? {prod, 3'd0} : (sub1 ? x1 - y1 : x1 + y1);
  end

  // stage 3: normalisation
  logic [5:0]   lead;
  logic [W-1:0] nm;
  always_comb begin
    lead = 6'd0;
    for (int i = 0; i < W; i++) if (m2[i]) lead = 6'(i);
  end
  assign nm = m2 << (6'd50 - lead);

  always_ff @(posedge clk) begin
    s3 <= s2; rm3 <= rm2; sp3 <= sp2; spr3 <= spr2; spf3 <= spf2;
    e3  <= e2 + 11'(lead) - 11'd49;
    z3  <= ~nm[50];
    fr3 <= nm[49:27];
    g3  <= nm[26];
    st3 <= |nm[25:0];
  end

  // stage 4: rounding, range check, packing
  logic inc, cy, nx, big;
  logic [22:0] fr;
  logic signed [10:0] ef;
  logic [31:0] r_c;
  logic [4:0]  f_c;

  always_comb
    case (rm3)
      2'b00:   inc = g3 & (st3 | fr3[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~s3 & (g3 | st3);
      default: inc = s3 & (g3 | st3);
    endcase

  assign {cy, fr} = {1'b0, fr3} + 24'(inc);
  assign ef  = e3 + 11'(cy);
  assign nx  = g3 | st3;
  assign big = (rm3 == 2'b00) | ((rm3 == 2'b10) & ~s3) | ((rm3 == 2'b11) & s3);

  always_comb begin
    if (sp3)                   begin r_c = spr3; f_c = spf3; end
    else if (z3)               begin r_c = {rm3 == 2'b11, 31'd0}; f_c = 5'd0; end
    else if (ef >= 11'sd255)   begin
      r_c = big ? {s3, 8'hFF, 23'd0} : {s3, 8'hFE, 23'h7FFFFF};
      f_c = 5'b00101;
    end
    else if (ef < 11'sd1)      begin r_c = {s3, 31'd0}; f_c = 5'b00011; end
    else                       begin r_c = {s3, ef[7:0], fr}; f_c = {4'd0, nx}; end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; res <= 32'd0; exc <= 5'd0;
    end else begin
      out_valid <= v3; res <= r_c; exc <= f_c;
    end

  // checks
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 3'd0;
    else if (warm != 3'd4) warm <= warm + 3'd1;

  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));
  a_r7_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res[30:23] == 8'hFF && res[22:0] != 23'd0) |-> (res == QNAN));
  a_r7_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc[4]) |-> (res == QNAN));
  a_r5_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res[30:23] == 8'd0) |-> (res[22:0] == 23'd0));
  a_r6_ovf_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc[2]) |-> (exc[0] && (res[30:0] == 31'h7F800000 || res[30:0] == 31'h7F7FFFFF)));
endmodule

// File: tb/tb_fp32_arith_pipe.sv
`timescale 1ns/1ps
module tb_fp32_arith_pipe;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [1:0]  op_sel = '0, rmode = '0;
  logic        out_valid;
  logic [31:0] res;
  logic [4:0]  exc;
  int total = 0, bad = 0;

  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, MUL = 2'b10;
  localparam logic [1:0] RNE = 2'b00, RZ = 2'b01, RUP = 2'b10, RDN = 2'b11;

  fp32_arith_pipe dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .op_sel(op_sel), .rmode(rmode), .out_valid(out_valid), .res(res), .exc(exc));

  always #10 clk = ~clk;

  task automatic check(input logic v, input logic [31:0] r, input logic [4:0] f, input string tag);
    total++;
    if (!(out_valid === v && res === r && exc === f)) begin
      bad++;
      $display("FAIL %s: got v=%0b res=%h exc=%b, expected v=%0b res=%h exc=%b",
               tag, out_valid, res, exc, v, r, f);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                     input logic [1:0] rm, input logic [31:0] er, input logic [4:0] ef, input string tag);
    @(negedge clk); a_in = a; b_in = b; op_sel = op; rmode = rm; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b1, er, ef, tag);
  endtask

  task automatic t_reset;
    check(1'b0, 32'h0, 5'h0, "R1 reset state");
  endtask

  task automatic t_basic;
    run(32'h3F800000, 32'h40000000, ADD, RNE, 32'h40400000, 5'b00000, "R2 1+2");
    run(32'h3F800000, 32'h40000000, SUB, RNE, 32'hBF800000, 5'b00000, "R2 1-2");
    run(32'h3FC00000, 32'h40000000, MUL, RNE, 32'h40400000, 5'b00000, "R2 1.5*2");
    run(32'h40400000, 32'hBF000000, 2'b11, RZ, 32'hBFC00000, 5'b00000, "R2 3*-0.5");
  endtask

  task automatic t_round;
    run(32'h3F800000, 32'h33800000, ADD, RNE, 32'h3F800000, 5'b00001, "R3 tie to even down");
    run(32'h3F800001, 32'h33800000, ADD, RNE, 32'h3F800002, 5'b00001, "R3 tie to even up");
    run(32'h3F800000, 32'h33C00000, ADD, RNE, 32'h3F800001, 5'b00001, "R3 above half");
    run(32'h3F800000, 32'h33800000, ADD, RZ,  32'h3F800000, 5'b00001, "R3 to zero");
    run(32'h3F800000, 32'h33800000, ADD, RUP, 32'h3F800001, 5'b00001, "R3 up positive");
    run(32'h3F800000, 32'h33800000, ADD, RDN, 32'h3F800000, 5'b00001, "R3 down positive");
    run(32'hBF800000, 32'hB3800000, ADD, RDN, 32'hBF800001, 5'b00001, "R3 down negative");
    run(32'hBF800000, 32'hB3800000, ADD, RUP, 32'hBF800000, 5'b00001, "R3 up negative");
  endtask

  task automatic t_overflow;
    run(32'h7F7FFFFF, 32'h40000000, MUL, RNE, 32'h7F800000, 5'b00101, "R6 nearest");
    run(32'h7F7FFFFF, 32'h40000000, MUL, RZ,  32'h7F7FFFFF, 5'b00101, "R6 to zero");
    run(32'h7F7FFFFF, 32'h40000000, MUL, RUP, 32'h7F800000, 5'b00101, "R6 up");
    run(32'h7F7FFFFF, 32'h40000000, MUL, RDN, 32'h7F7FFFFF, 5'b00101, "R6 down");
    run(32'hFF7FFFFF, 32'h40000000, MUL, RDN, 32'hFF800000, 5'b00101, "R6 neg down");
    run(32'hFF7FFFFF, 32'h40000000, MUL, RUP, 32'hFF7FFFFF, 5'b00101, "R6 neg up");
    run(32'h7F7FFFFF, 32'h73000000, ADD, RNE, 32'h7F800000, 5'b00101, "R6 round carry nearest");
    run(32'h7F7FFFFF, 32'h73000000, ADD, RUP, 32'h7F800000, 5'b00101, "R6 round carry up");
    run(32'h7F7FFFFF, 32'h73000000, ADD, RZ,  32'h7F7FFFFF, 5'b00001, "R6 R8 no carry to zero");
    run(32'h7F7FFFFF, 32'h73000000, ADD, RDN, 32'h7F7FFFFF, 5'b00001, "R6 R8 no carry down");
  endtask

  task automatic t_flush;
    run(32'h00800000, 32'h3F000000, MUL, RNE, 32'h00000000, 5'b00011, "R5 product underflow");
    run(32'h80800000, 32'h3F000000, MUL, RNE, 32'h80000000, 5'b00011, "R5 negative underflow");
    run(32'h00800001, 32'h00800000, SUB, RNE, 32'h00000000, 5'b00011, "R5 difference underflow");
    run(32'h00000001, 32'h3F800000, ADD, RNE, 32'h3F800000, 5'b00000, "R4 subnormal addend");
    run(32'h00400000, 32'h7F000000, MUL, RNE, 32'h00000000, 5'b00000, "R4 subnormal factor");
    run(32'h80400000, 32'h3F800000, MUL, RNE, 32'h80000000, 5'b00000, "R4 signed flush");
  endtask

  task automatic t_special;
    run(32'h7F800000, 32'hFF800000, ADD, RNE, 32'h7FC00000, 5'b10000, "R7 inf plus -inf");
    run(32'h7F800000, 32'h7F800000, SUB, RNE, 32'h7FC00000, 5'b10000, "R7 inf minus inf");
    run(32'h00000000, 32'h7F800000, MUL, RNE, 32'h7FC00000, 5'b10000, "R7 zero times inf");
    run(32'h7FC00001, 32'h3F800000, ADD, RNE, 32'h7FC00000, 5'b00000, "R7 quiet NaN");
    run(32'h7F800001, 32'h3F800000, MUL, RNE, 32'h7FC00000, 5'b10000, "R7 signaling NaN");
    run(32'h7F800000, 32'h3F800000, ADD, RNE, 32'h7F800000, 5'b00000, "R10 inf plus finite");
    run(32'h7F800000, 32'hFF800000, SUB, RNE, 32'h7F800000, 5'b00000, "R10 inf minus -inf");
    run(32'hFF800000, 32'hBF800000, MUL, RNE, 32'h7F800000, 5'b00000, "R10 sign of product");
  endtask

  task automatic t_zero;
    run(32'h3F800000, 32'h3F800000, SUB, RNE, 32'h00000000, 5'b00000, "R9 cancel nearest");
    run(32'h3F800000, 32'h3F800000, SUB, RDN, 32'h80000000, 5'b00000, "R9 cancel down");
    run(32'h00000000, 32'h80000000, ADD, RNE, 32'h00000000, 5'b00000, "R9 +0 + -0");
    run(32'h00000000, 32'h80000000, ADD, RDN, 32'h80000000, 5'b00000, "R9 +0 + -0 down");
    run(32'h80000000, 32'h80000000, ADD, RUP, 32'h80000000, 5'b00000, "R9 -0 + -0");
  endtask

  task automatic t_stream;
    logic [31:0] va [8] = '{32'h3F800000, 32'h7F7FFFFF, 32'h00800000, 32'h3F800000,
                            32'h7F800000, 32'h3FC00000, 32'h3F800001, 32'h3F800000};
    logic [31:0] vb [8] = '{32'h40000000, 32'h73000000, 32'h3F000000, 32'h33800000,
                            32'hFF800000, 32'h40000000, 32'h33800000, 32'h3F800000};
    logic [1:0]  vo [8] = '{ADD, ADD, MUL, ADD, ADD, MUL, ADD, SUB};
    logic [1:0]  vr [8] = '{RNE, RZ, RNE, RUP, RNE, RDN, RNE, RDN};
    logic [31:0] xr [8] = '{32'h40400000, 32'h7F7FFFFF, 32'h00000000, 32'h3F800001,
                            32'h7FC00000, 32'h40400000, 32'h3F800002, 32'h80000000};
    logic [4:0]  xf [8] = '{5'b00000, 5'b00001, 5'b00011, 5'b00001,
                            5'b10000, 5'b00000, 5'b00001, 5'b00000};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 4) check(1'b1, xr[i-4], xf[i-4], $sformatf("R1 stream slot %0d", i - 4));
      else begin
        total++;
        if (out_valid !== 1'b0) begin
          bad++;
          $display("FAIL R1 stream idle %0d: got v=%0b expected v=0", i, out_valid);
        end
      end
      if (i < 8) begin
        a_in = va[i]; b_in = vb[i]; op_sel = vo[i]; rmode = vr[i]; in_valid = 1'b1;
      end else in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_round;
    t_overflow;
    t_flush;
    t_special;
    t_zero;
    t_stream;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: got no completion, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule